// File: doc/BRIEF.md
# Rewindable Narrowing FIFO

This block is a single-clock queue of 36-bit entries. A wide port both loads and unloads whole entries. A direction pin chooses between write and read. A second, narrow port unloads the same entries as a series of 18-bit or 9-bit slices, upper slice first. Two strobes control the stored contents. A partial reset empties the queue but keeps the flag configuration and the narrow width. A rewind strobe moves the read side back to the first entry written since the last reset, so that data can be replayed by ordinary reads.

Both data sides use valid/ready rules. On the wide port, a transfer happens on a rising edge where `a_valid` and `a_ready` are both high. A write is stalled only by a full queue. A read is stalled by an empty queue, by a narrow pull in the same cycle, or by a word that is only partly read. On the narrow port, `b_avail` says that a slice may be taken, and `b_pull` takes one. Read results come back registered, each with its own valid pulse. The narrow side cannot stall its output.

Two threshold flags warn of a nearly empty or nearly full queue. Their offsets can be loaded in parallel. They default to a depth-dependent value.

Top module: `rtx_fifo`

## Requirements
- R1: While `a_dir` is 1 (write), `a_ready` equals "partial reset released and occupancy below DEPTH". An entry is stored on each edge with `a_valid` and `a_ready` both high.
- R2: While `a_dir` is 0 (read), an accepted transfer puts the oldest entry on `a_rdata` on that edge, with `a_rvalid` high for one cycle. `a_rdata_oe` is low while `a_dir` is 1, which marks the wide outputs as not driven.
- R3: A write offered while the queue is full, and any read offered while it is empty, change neither the contents nor the occupancy.
- R4: `b_pull` with `b_avail` high returns one slice on the next edge, with `b_rvalid` high. With `b_size`=0 the slices are bits [35:18] and then [17:0]. With `b_size`=1 they are [35:27], [26:18], [17:9] and [8:0], placed in `b_rdata[8:0]` with the upper bits zero. The entry leaves the queue with its last slice.
- R5: A narrow pull has priority over a wide read in the same cycle. A wide read is accepted only when no word is partly read.
- R6: In a cycle with `rt_n` low, the read position returns to the first location and to slice 0. No read is accepted in that cycle, but writes still proceed. This applies only when the FWFT parameter is 0.
- R7: In a cycle with `prst_n` low, both positions return to the first location and the queue becomes empty. `a_rdata` becomes zero and no transfer is accepted. The flag offsets and `b_rdata` are kept.
- R8: `empty` means occupancy 0 and `full` means occupancy DEPTH. `almost_empty` means occupancy <= the empty offset. `almost_full` means DEPTH minus occupancy <= the full offset. All four follow the edge that changed the occupancy.
- R9: A full reset sets both offsets to 8 (DEPTH<=256), 16 (DEPTH<=4096) or 64 (larger depths). `cfg_load` high loads `cfg_ae` and `cfg_af` on the edge.
- R10: With `rst_n` low on an edge, the queue becomes empty and `a_rdata`, `b_rdata` and both valid outputs become zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous full reset, active low |
| prst_n | input | 1 | Partial reset, active low |
| rt_n | input | 1 | Rewind strobe, active low |
| a_dir | input | 1 | Wide port direction: 1 write, 0 read |
| a_valid | input | 1 | Wide port transfer request |
| a_ready | output | 1 | Wide port can transfer this cycle |
| a_wdata | input | 36 | Wide write entry |
| a_rdata | output | 36 | Wide read entry, registered |
| a_rvalid | output | 1 | Pulse: a_rdata holds a new entry |
| a_rdata_oe | output | 1 | Wide output drive enable (low while writing) |
| b_size | input | 1 | Narrow width: 0 gives 18 bits, 1 gives 9 bits (static) |
| b_pull | input | 1 | Narrow slice request |
| b_avail | output | 1 | A narrow slice may be taken |
| b_rdata | output | 18 | Narrow slice, registered |
| b_rvalid | output | 1 | Pulse: b_rdata holds a new slice |
| cfg_load | input | 1 | Load both flag offsets |
| cfg_ae | input | $clog2(DEPTH)+1 | Almost-empty offset to load |
| cfg_af | input | $clog2(DEPTH)+1 | Almost-full offset to load |
| empty | output | 1 | Occupancy is zero |
| full | output | 1 | Occupancy is DEPTH |
| almost_empty | output | 1 | Occupancy at or below the empty offset |
| almost_full | output | 1 | Free space at or below the full offset |

## Verification
The ready outputs are combinational from the current state and inputs. They are due in the same cycle, so the bench compares them 1 ns after it changes the inputs and before the next rising edge. Read data, valid pulses and all four flags pass through one register. They are due after the edge that accepted the transfer or strobe, and the bench compares them at the following falling edge against a behavioural model that is advanced on that same rising edge. Each directed phase adds named spot checks: the first replayed entry after a rewind, a zeroed wide output after a partial reset, and loaded offsets that survive a partial reset.

// File: rtl/rtx_fifo_pkg.sv
package rtx_fifo_pkg;
  localparam int WIDE_W   = 36;
  localparam int NARROW_W = 18;
  localparam int BYTE_W   = 9;
  localparam int N_HALF   = WIDE_W / NARROW_W;
  localparam int N_BYTE   = WIDE_W / BYTE_W;

  // flag offset used until software loads one, chosen by queue depth
  function automatic int dflt_offset(input int depth);
    if (depth <= 256)  return 8;
    if (depth <= 4096) return 16;
    return 64;
  endfunction
endpackage

// File: rtl/rtx_fifo_ptrs.sv
module rtx_fifo_ptrs #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          push,
  input  logic          pop,
  input  logic          rewind,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic [PW-1:0] count
);
  logic [PW-1:0] wr_q, rd_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      if (push) wr_q <= wr_q + 1'b1;
      if (rewind)   rd_q <= '0;
      else if (pop) rd_q <= rd_q + 1'b1;
    end
  end

  // the extra top bit keeps "full" apart from "empty"
  assign count   = wr_q - rd_q;
  assign wr_addr = wr_q[AW-1:0];
  assign rd_addr = rd_q[AW-1:0];
endmodule

// File: rtl/rtx_fifo_mem.sv
module rtx_fifo_mem #(
  parameter int DEPTH = 64,
  parameter int W     = 36,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/rtx_fifo_slicer.sv
module rtx_fifo_slicer
  import rtx_fifo_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                take,
  input  logic                size9,
  input  logic [WIDE_W-1:0]   word,
  output logic                at_start,
  output logic                last,
  output logic [NARROW_W-1:0] rdata,
  output logic                rvalid
);
  localparam int SW = $clog2(N_BYTE);
  localparam int HW = $clog2(N_HALF);

  logic [SW-1:0]       idx;
  logic [BYTE_W-1:0]   bytes_w [N_BYTE];
  logic [NARROW_W-1:0] halves  [N_HALF];
  logic [NARROW_W-1:0] pick;

  // slice 0 is the most significant part of the entry
  for (genvar g = 0; g < N_BYTE; g++) begin : g_byte
    assign bytes_w[g] = word[WIDE_W-1-g*BYTE_W -: BYTE_W];
  end
  for (genvar g = 0; g < N_HALF; g++) begin : g_half
    assign halves[g] = word[WIDE_W-1-g*NARROW_W -: NARROW_W];
  end

  assign at_start = (idx == '0);
  assign last     = size9 ? (idx == SW'(N_BYTE - 1)) : (idx == SW'(N_HALF - 1));

  always_comb begin
    if (size9) pick = NARROW_W'(bytes_w[idx]);
    else       pick = halves[idx[HW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx    <= '0;
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= take;
      if (take) rdata <= pick;
      if (clear)          idx <= '0;
      else if (take)      idx <= last ? '0 : idx + 1'b1;
    end
  end
endmodule

// File: rtl/rtx_fifo_flags.sv
module rtx_fifo_flags #(
  parameter int DEPTH = 64,
  localparam int PW = $clog2(DEPTH) + 1
) (
  input  logic [PW-1:0] count,
  input  logic [PW-1:0] ae_off,
  input  logic [PW-1:0] af_off,
  output logic          empty,
  output logic          full,
  output logic          almost_empty,
  output logic          almost_full
);
  logic [PW-1:0] space;

  assign space        = PW'(DEPTH) - count;
  assign empty        = (count == '0);
  assign full         = (count == PW'(DEPTH));
  assign almost_empty = (count <= ae_off);
  assign almost_full  = (space <= af_off);
endmodule

// File: rtl/rtx_fifo.sv
module rtx_fifo
  import rtx_fifo_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int FWFT  = 0,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                prst_n,
  input  logic                rt_n,
  input  logic                a_dir,
  input  logic                a_valid,
  output logic                a_ready,
  input  logic [WIDE_W-1:0]   a_wdata,
  output logic [WIDE_W-1:0]   a_rdata,
  output logic                a_rvalid,
  output logic                a_rdata_oe,
  input  logic                b_size,
  input  logic                b_pull,
  output logic                b_avail,
  output logic [NARROW_W-1:0] b_rdata,
  output logic                b_rvalid,
  input  logic                cfg_load,
  input  logic [PW-1:0]       cfg_ae,
  input  logic [PW-1:0]       cfg_af,
  output logic                empty,
  output logic                full,
  output logic                almost_empty,
  output logic                almost_full
);
  localparam logic [PW-1:0] OFF_RST = PW'(dflt_offset(DEPTH));

  logic [AW-1:0]     wr_addr, rd_addr;
  logic [PW-1:0]     count;
  logic [PW-1:0]     ae_off_q, af_off_q;
  logic [WIDE_W-1:0] head;
  logic              rewind, push, pop, a_take, b_take;
  logic              at_start, last;

  // rewind exists only in the standard (non fall-through) variant
  if (FWFT == 0) begin : g_std
    assign rewind = !rt_n && prst_n;
  end else begin : g_fwft
    assign rewind = 1'b0;
  end

  assign a_rdata_oe = !a_dir;
  assign b_avail    = prst_n && rt_n && !empty;
  assign a_ready    = a_dir ? (prst_n && !full)
                            : (prst_n && rt_n && !empty && !b_pull && at_start);
  assign push   = a_valid && a_ready && a_dir;
  assign a_take = a_valid && a_ready && !a_dir;
  assign b_take = b_pull && b_avail;
  assign pop    = a_take || (b_take && last);

  rtx_fifo_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .clear(!prst_n), .push(push), .pop(pop),
    .rewind(rewind), .wr_addr(wr_addr), .rd_addr(rd_addr), .count(count)
  );

  rtx_fifo_mem #(.DEPTH(DEPTH), .W(WIDE_W)) u_mem (
    .clk(clk), .we(push), .waddr(wr_addr), .wdata(a_wdata),
    .raddr(rd_addr), .rdata(head)
  );

  rtx_fifo_slicer u_slice (
    .clk(clk), .rst_n(rst_n), .clear(!prst_n || rewind), .take(b_take),
    .size9(b_size), .word(head), .at_start(at_start), .last(last),
    .rdata(b_rdata), .rvalid(b_rvalid)
  );

  rtx_fifo_flags #(.DEPTH(DEPTH)) u_flags (
    .count(count), .ae_off(ae_off_q), .af_off(af_off_q), .empty(empty),
    .full(full), .almost_empty(almost_empty), .almost_full(almost_full)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ae_off_q <= OFF_RST;
      af_off_q <= OFF_RST;
    end else if (cfg_load) begin
      ae_off_q <= cfg_ae;
      af_off_q <= cfg_af;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_rdata  <= '0;
      a_rvalid <= 1'b0;
    end else begin
      a_rvalid <= a_take;
      if (!prst_n)     a_rdata <= '0;
      else if (a_take) a_rdata <= head;
    end
  end
endmodule

// File: rtl/rtx_fifo_chk.sv
module rtx_fifo_chk
  import rtx_fifo_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                prst_n,
  input logic                rt_n,
  input logic                a_dir,
  input logic                a_valid,
  input logic                a_ready,
  input logic [WIDE_W-1:0]   a_rdata,
  input logic                a_rvalid,
  input logic                b_size,
  input logic                b_pull,
  input logic [NARROW_W-1:0] b_rdata,
  input logic                b_rvalid,
  input logic                empty,
  input logic                full
);
  // R1: an accepted write leaves at least one entry behind
  a_r1_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (a_valid && a_dir && a_ready) |=> !empty);

  // R2: a wide valid pulse only follows an accepted wide read
  a_r2_rvalid_cause: assert property (@(posedge clk) disable iff (!rst_n)
    a_rvalid |-> $past(a_valid && a_ready && !a_dir));

  // R3: with nothing taken out, a full queue stays full
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (full && prst_n && rt_n && !b_pull && !(a_valid && !a_dir)) |=> full);

  // R4: byte mode keeps the upper narrow bits clear
  a_r4_byte_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (b_rvalid && b_size) |-> (b_rdata[NARROW_W-1:BYTE_W] == '0));

  // R6: nothing is read in a rewind cycle
  a_r6_rewind_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    !rt_n |=> (!a_rvalid && !b_rvalid));

  // R7: partial reset empties the queue and zeroes the wide output
  a_r7_partial_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !prst_n |=> (empty && a_rdata == '0));

  // R8: the two end flags never coincide
  a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty && full));
endmodule

bind rtx_fifo rtx_fifo_chk u_chk (
  .clk(clk), .rst_n(rst_n), .prst_n(prst_n), .rt_n(rt_n), .a_dir(a_dir),
  .a_valid(a_valid), .a_ready(a_ready), .a_rdata(a_rdata), .a_rvalid(a_rvalid),
  .b_size(b_size), .b_pull(b_pull), .b_rdata(b_rdata), .b_rvalid(b_rvalid),
  .empty(empty), .full(full)
);

// File: tb/tb_rtx_fifo.sv
module tb_rtx_fifo;
  import rtx_fifo_pkg::*;
  localparam int DEPTH = 64;
  localparam int PW = $clog2(DEPTH) + 1;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, prst_n = 1'b1, rt_n = 1'b1;
  logic a_dir = 1'b0, a_valid = 1'b0, b_size = 1'b0, b_pull = 1'b0, cfg_load = 1'b0;
  logic [35:0] a_wdata = '0;
  logic [PW-1:0] cfg_ae = '0, cfg_af = '0;
  logic a_ready, a_rvalid, a_rdata_oe, b_avail, b_rvalid;
  logic empty, full, almost_empty, almost_full;
  logic [35:0] a_rdata;
  logic [17:0] b_rdata;

  rtx_fifo #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .prst_n(prst_n), .rt_n(rt_n), .a_dir(a_dir),
    .a_valid(a_valid), .a_ready(a_ready), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .a_rvalid(a_rvalid), .a_rdata_oe(a_rdata_oe), .b_size(b_size), .b_pull(b_pull),
    .b_avail(b_avail), .b_rdata(b_rdata), .b_rvalid(b_rvalid), .cfg_load(cfg_load),
    .cfg_ae(cfg_ae), .cfg_af(cfg_af), .empty(empty), .full(full),
    .almost_empty(almost_empty), .almost_full(almost_full)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  string phase = "R10 reset";

  // behavioural reference: unbounded counters over a circular array
  logic [35:0] m_mem [DEPTH];
  int m_wr = 0, m_rd = 0, m_sl = 0, m_ae = 8, m_af = 8;
  logic [35:0] m_ard = '0;
  logic [17:0] m_brd = '0;
  logic m_arv = 1'b0, m_brv = 1'b0;
  logic wr_ok, a_ok, b_ok;
  logic [35:0] head;

  function automatic logic [35:0] pat(input int i);
    return {4'(i), 8'(i * 3 + 1), 8'(~i), 8'(i + 90), 8'(i * 7)};
  endfunction

  function automatic int m_cnt();
    return m_wr - m_rd;
  endfunction

  function automatic logic exp_a_ready();
    if (a_dir) return prst_n && (m_cnt() < DEPTH);
    return prst_n && rt_n && (m_cnt() > 0) && !b_pull && (m_sl == 0);
  endfunction

  function automatic logic exp_b_avail();
    return prst_n && rt_n && (m_cnt() > 0);
  endfunction

  function automatic logic [17:0] m_slice(input logic [35:0] w);
    if (b_size) return 18'((w >> (27 - 9 * m_sl)) & 36'h1FF);
    return 18'((w >> (18 - 18 * m_sl)) & 36'h3FFFF);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_wr = 0; m_rd = 0; m_sl = 0; m_ae = 8; m_af = 8;
      m_ard = '0; m_brd = '0; m_arv = 1'b0; m_brv = 1'b0;
    end else begin
      wr_ok = a_valid && a_dir && exp_a_ready();
      a_ok  = a_valid && !a_dir && exp_a_ready();
      b_ok  = b_pull && exp_b_avail();
      head  = m_mem[m_rd % DEPTH];
      m_arv = a_ok;
      m_brv = b_ok;
      if (a_ok) m_ard = head;
      if (b_ok) m_brd = m_slice(head);
      if (cfg_load) begin m_ae = int'(cfg_ae); m_af = int'(cfg_af); end
      if (!prst_n) begin
        m_wr = 0; m_rd = 0; m_sl = 0; m_ard = '0;
      end else begin
        if (wr_ok) begin m_mem[m_wr % DEPTH] = a_wdata; m_wr++; end
        if (!rt_n) begin m_rd = 0; m_sl = 0; end
        else if (a_ok) m_rd++;
        else if (b_ok) begin
          if (m_sl == (b_size ? 3 : 1)) begin m_sl = 0; m_rd++; end
          else m_sl++;
        end
      end
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [35:0] act, input logic [35:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s [%s] %s: actual=%h expected=%h", req, phase, what, act, exp);
    end
  endtask

  task automatic cmp_state();
    chk("R2", "a_rdata", a_rdata, m_ard);
    chk("R2", "a_rvalid", 36'(a_rvalid), 36'(m_arv));
    chk("R4", "b_rdata", 36'(b_rdata), 36'(m_brd));
    chk("R4", "b_rvalid", 36'(b_rvalid), 36'(m_brv));
    chk("R8", "empty", 36'(empty), 36'(m_cnt() == 0));
    chk("R8", "full", 36'(full), 36'(m_cnt() == DEPTH));
    chk("R8", "almost_empty", 36'(almost_empty), 36'(m_cnt() <= m_ae));
    chk("R8", "almost_full", 36'(almost_full), 36'((DEPTH - m_cnt()) <= m_af));
  endtask

  // inputs were just set after a falling edge; check readiness, then cross one edge
  task automatic tick();
    #1;
    chk("R1", "a_ready", 36'(a_ready), 36'(exp_a_ready()));
    chk("R4", "b_avail", 36'(b_avail), 36'(exp_b_avail()));
    chk("R2", "a_rdata_oe", 36'(a_rdata_oe), 36'(!a_dir));
    @(negedge clk);
    cmp_state();
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R10 watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [35:0] w;
    @(negedge clk);
    cmp_state();
    tick(); tick();
    chk("R10", "empty after reset", 36'(empty), 36'd1);
    chk("R10", "a_rdata after reset", a_rdata, '0);
    chk("R10", "b_rvalid after reset", 36'(b_rvalid), 36'd0);
    rst_n = 1'b1;

    phase = "R1 wide writes";
    a_dir = 1'b1; a_valid = 1'b1;
    for (int i = 0; i < 12; i++) begin
      a_wdata = pat(i);
      tick();
      if (i == 7) chk("R9", "default offset holds at 8", 36'(almost_empty), 36'd1);
      if (i == 8) chk("R9", "default offset passed at 9", 36'(almost_empty), 36'd0);
    end
    a_valid = 1'b0; a_dir = 1'b0;
    tick();

    phase = "R4 18-bit slices";
    b_pull = 1'b1; tick(); b_pull = 1'b0;
    w = pat(0);
    chk("R4", "first upper half", 36'(b_rdata), 36'(w[35:18]));
    for (int i = 0; i < 4; i++) begin
      b_pull = 1'b1; tick(); b_pull = 1'b0; tick();
    end

    phase = "R5 narrow priority";
    a_valid = 1'b1; b_pull = 1'b1;
    tick(); tick();
    b_pull = 1'b0;
    tick();
    chk("R5", "wide read blocked mid-word", 36'(a_rvalid), 36'd0);
    b_pull = 1'b1; tick(); b_pull = 1'b0;
    tick(); tick();
    chk("R2", "wide read order", a_rdata, pat(5));
    a_valid = 1'b0;

    phase = "R6 rewind";
    rt_n = 1'b0; a_dir = 1'b1; a_valid = 1'b1; a_wdata = pat(12); b_pull = 1'b1;
    tick();
    rt_n = 1'b1; b_pull = 1'b0; a_dir = 1'b0;
    tick();
    chk("R6", "replay starts at first entry", a_rdata, pat(0));
    phase = "R3 read past empty";
    for (int i = 0; i < 15; i++) tick();
    chk("R3", "empty after draining", 36'(empty), 36'd1);
    chk("R3", "no read when empty", 36'(a_rvalid), 36'd0);

    phase = "R3 write past full";
    a_dir = 1'b1;
    for (int i = 0; i < 70; i++) begin a_wdata = pat(100 + i); tick(); end
    chk("R3", "full after overfill", 36'(full), 36'd1);
    a_dir = 1'b0;
    tick(); tick();
    chk("R3", "dropped writes absent", a_rdata, pat(101));
    a_valid = 1'b0;

    phase = "R7 partial reset";
    cfg_load = 1'b1; cfg_ae = PW'(3); cfg_af = PW'(5);
    tick();
    cfg_load = 1'b0; prst_n = 1'b0; a_dir = 1'b1; a_valid = 1'b1; a_wdata = pat(200);
    tick();
    prst_n = 1'b1; a_valid = 1'b0;
    chk("R7", "empty after partial reset", 36'(empty), 36'd1);
    chk("R7", "wide output zeroed", a_rdata, '0);
    a_valid = 1'b1;
    for (int i = 0; i < 4; i++) begin a_wdata = pat(210 + i); tick(); end
    a_valid = 1'b0;
    tick();
    chk("R9", "loaded empty offset kept", 36'(almost_empty), 36'd0);

    phase = "R4 9-bit slices";
    prst_n = 1'b0; tick(); prst_n = 1'b1;
    b_size = 1'b1; a_valid = 1'b1;
    for (int i = 0; i < 3; i++) begin a_wdata = pat(300 + i); tick(); end
    a_valid = 1'b0;
    b_pull = 1'b1; tick();
    w = pat(300);
    chk("R4", "first byte slice", 36'(b_rdata), 36'(w[35:27]));
    for (int i = 0; i < 13; i++) tick();
    b_pull = 1'b0;
    tick();
    chk("R4", "all bytes consumed", 36'(empty), 36'd1);

    phase = "R10 reset again";
    rst_n = 1'b0; tick(); rst_n = 1'b1; a_dir = 1'b0;
    tick();
    chk("R10", "empty after second reset", 36'(empty), 36'd1);
    chk("R10", "b_rdata after second reset", 36'(b_rdata), 36'd0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule